// File: doc/BRIEF.md
# UART status register and interrupt request logic

This block holds the eight status flags of an asynchronous serial port and drives its active-low interrupt request. It sits between the receiver and transmitter datapaths, which report events to it as single-cycle strobes, and the processor side, which reads received data, reads status and writes characters. Each flag has its own set and clear events. Three slow external inputs (an external status level, a peripheral status line and clear-to-send) are brought into the clock domain through flop synchronizers before they are used.

Interrupts come from five sources: a received character, the transmit holding register becoming empty, the whole transmitter becoming idle, a falling edge on the peripheral status line, and a rising clear-to-send edge while the transmitter is idle. Each source keeps its own pending flag. The request output is low while the master enable is on and any pending flag is set. The holding-empty source is also gated by a second enable. Three extra outputs give the data-ready flag inverted, the OR of the overrun and parity flags, and the framing flag.

Top module: `uart_stat_irq`

## Requirements
- R1: Status bit 0 (data ready) is set one cycle after `rx_load` and cleared by `rd_data`; when both strobe in the same cycle it ends set. `rdy_n` is always the inverse of bit 0.
- R2: Every `rx_load` rewrites status bit 1 (overrun): it becomes 1 if bit 0 was set and `rd_data` was not strobed in that cycle, otherwise 0. It holds between loads.
- R3: Every `rx_load` copies `rx_par_bad` into status bit 2 (parity) and `rx_stop_bad` into status bit 3 (framing). Both hold between loads. `err_op` equals bit 1 OR bit 2, and `err_frm` equals bit 3.
- R4: Status bit 4 is the inverted, synchronized level of `ext_stat_n`. It follows a change within four cycles.
- R5: Status bit 5 is set by a synchronized high-to-low edge of `periph_stat` and cleared by `rd_status`. A rising edge leaves it unchanged.
- R6: After reset the status reads 8'hC0. Bit 7 (holding empty) is cleared by `wr_char` and set by `tx_hold_xfer`; when both strobe together it ends clear. Bit 6 (shifter empty) is cleared by `tx_hold_xfer` and set by `tx_shift_done`.
- R7: `irq_n` is high whenever `ctl_ie` is low, whatever is pending.
- R8: With `ctl_ie` high, `irq_n` is low while status bit 0 is set and returns high after `rd_data`.
- R9: A rise of bit 7 makes a holding-empty request pending. It drives `irq_n` low only while `ctl_tr` is high. `rd_status` or `wr_char` clears it.
- R10: A rise of (bit 7 AND bit 6) makes a transmitter-idle request pending. This source does not depend on `ctl_tr`. `rd_status` or `wr_char` clears it.
- R11: With `ctl_ie` high, `irq_n` is low while status bit 5 is set. `rd_status` releases it.
- R12: A synchronized rising edge of `cts` while bits 7 and 6 are both set makes a request pending, which `rd_status` clears. A rising edge while either bit is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_load | input | 1 | Receiver moved a character into its holding register |
| rx_par_bad | input | 1 | Parity mismatch of that character |
| rx_stop_bad | input | 1 | Stop bit of that character was low |
| tx_hold_xfer | input | 1 | Transmit holding register moved into the shifter |
| tx_shift_done | input | 1 | Shifter finished a full character |
| ext_stat_n | input | 1 | External status level, active low, asynchronous |
| periph_stat | input | 1 | Peripheral status line, asynchronous |
| cts | input | 1 | Clear-to-send, asynchronous |
| ctl_ie | input | 1 | Master interrupt enable |
| ctl_tr | input | 1 | Enable for the holding-empty interrupt |
| rd_data | input | 1 | Processor read of received data |
| rd_status | input | 1 | Processor read of status |
| wr_char | input | 1 | Processor write of a character |
| status | output | 8 | Status flags, bit 0 to bit 7 as in R1 to R6 |
| irq_n | output | 1 | Interrupt request, active low |
| rdy_n | output | 1 | Inverse of data ready |
| err_op | output | 1 | Overrun OR parity |
| err_frm | output | 1 | Framing error |

## Verification
The assertions assume that every strobe is a clean single-cycle pulse synchronous to `clk`, and that the control and strobe inputs never carry unknown values after reset. They also assume the receiver cause inputs are valid in the same cycle as `rx_load`. The bench drives all strobes and controls just after a falling clock edge, for one cycle each. It holds every asynchronous input stable for at least four cycles, so that each edge passes the synchronizer exactly once before the flags are sampled.

// File: rtl/uart_stat_irq.sv
module uart_stat_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_load,
  input  logic       rx_par_bad,
  input  logic       rx_stop_bad,
  input  logic       tx_hold_xfer,
  input  logic       tx_shift_done,
  input  logic       ext_stat_n,
  input  logic       periph_stat,
  input  logic       cts,
  input  logic       ctl_ie,
  input  logic       ctl_tr,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       wr_char,
  output logic [7:0] status,
  output logic       irq_n,
  output logic       rdy_n,
  output logic       err_op,
  output logic       err_frm
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] es_sh, psi_sh, cts_sh;
  logic psi_prev, cts_prev;
  logic rdy, ovr, par, frm, psi, tsre, thre;
  logic thre_q, idle_q;
  logic pend_thre, pend_idle, pend_cts;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          es_sh  <= '1;
          psi_sh <= '1;
          cts_sh <= '0;
        end else begin
          es_sh  <= {es_sh[TOP-1:0], ext_stat_n};
          psi_sh <= {psi_sh[TOP-1:0], periph_stat};
          cts_sh <= {cts_sh[TOP-1:0], cts};
        end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          es_sh  <= '1;
          psi_sh <= '1;
          cts_sh <= '0;
        end else begin
          es_sh  <= ext_stat_n;
          psi_sh <= periph_stat;
          cts_sh <= cts;
        end
    end
  endgenerate

  wire psi_fall = psi_prev & ~psi_sh[TOP];
  wire cts_rise = ~cts_prev & cts_sh[TOP];
  wire idle     = thre & tsre;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psi_prev <= 1'b1;
      cts_prev <= 1'b0;
      rdy <= 1'b0; ovr <= 1'b0; par <= 1'b0; frm <= 1'b0;
      psi <= 1'b0;
      tsre <= 1'b1; thre <= 1'b1;
      thre_q <= 1'b1; idle_q <= 1'b1;
      pend_thre <= 1'b0; pend_idle <= 1'b0; pend_cts <= 1'b0;
    end else begin
      psi_prev <= psi_sh[TOP];
      cts_prev <= cts_sh[TOP];
      if (rx_load) begin
        rdy <= 1'b1;
        ovr <= rdy & ~rd_data;
        par <= rx_par_bad;
        frm <= rx_stop_bad;
      end else if (rd_data) begin
        rdy <= 1'b0;
      end
      if (psi_fall)       psi <= 1'b1;
      else if (rd_status) psi <= 1'b0;
      if (wr_char)           thre <= 1'b0;
      else if (tx_hold_xfer) thre <= 1'b1;
      if (tx_hold_xfer)       tsre <= 1'b0;
      else if (tx_shift_done) tsre <= 1'b1;
      thre_q <= thre;
      idle_q <= idle;
      if (thre & ~thre_q)             pend_thre <= 1'b1;
      else if (rd_status | wr_char)   pend_thre <= 1'b0;
      if (idle & ~idle_q)             pend_idle <= 1'b1;
      else if (rd_status | wr_char)   pend_idle <= 1'b0;
      if (cts_rise & idle)            pend_cts <= 1'b1;
      else if (rd_status)             pend_cts <= 1'b0;
    end

  assign status  = {thre, tsre, psi, ~es_sh[TOP], frm, par, ovr, rdy};
  assign irq_n   = ~(ctl_ie & (rdy | (ctl_tr & pend_thre) | pend_idle | psi | pend_cts));
  assign rdy_n   = ~rdy;
  assign err_op  = ovr | par;
  assign err_frm = frm;
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_load,
  input logic       rx_par_bad,
  input logic       rd_data,
  input logic       wr_char,
  input logic       ctl_ie,
  input logic [7:0] status,
  input logic       irq_n
);
  a_r1_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> status[0]);
  a_r2_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && status[0] && !rd_data |=> status[1]);
  a_r3_parity_load: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> status[2] == $past(rx_par_bad));
  a_r6_thre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_char |=> !status[7]);
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ie |-> irq_n);
  a_r8_data_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ie && status[0] |-> !irq_n);
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_par_bad(rx_par_bad),
  .rd_data(rd_data), .wr_char(wr_char), .ctl_ie(ctl_ie),
  .status(status), .irq_n(irq_n)
);

// File: tb/uart_stat_irq_tb.sv
module uart_stat_irq_tb;
  logic clk = 0, rst_n = 0;
  logic rx_load = 0, rx_par_bad = 0, rx_stop_bad = 0;
  logic tx_hold_xfer = 0, tx_shift_done = 0;
  logic ext_stat_n = 1, periph_stat = 1, cts = 0;
  logic ctl_ie = 0, ctl_tr = 0;
  logic rd_data = 0, rd_status = 0, wr_char = 0;
  logic [7:0] status;
  logic irq_n, rdy_n, err_op, err_frm;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_stat_irq u_dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R6 reset status", status, 8'hC0);
    chk("R7 reset irq_n", {7'd0, irq_n}, 8'd1);
    chk("R1 reset rdy_n", {7'd0, rdy_n}, 8'd1);
  endtask

  task automatic t_rx;
    ctl_ie = 0;
    rx_load = 1; rx_par_bad = 1; rx_stop_bad = 0; cyc(); rx_load = 0; rx_par_bad = 0;
    chk("R1 ready set", {7'd0, status[0]}, 8'd1);
    chk("R1 rdy_n", {7'd0, rdy_n}, 8'd0);
    chk("R3 parity/frame", {6'd0, status[3:2]}, 8'd1);
    chk("R2 no overrun", {7'd0, status[1]}, 8'd0);
    chk("R3 err_op", {7'd0, err_op}, 8'd1);
    chk("R7 masked rx", {7'd0, irq_n}, 8'd1);
    rx_load = 1; rx_stop_bad = 1; cyc(); rx_load = 0; rx_stop_bad = 0;
    chk("R2 overrun set", {7'd0, status[1]}, 8'd1);
    chk("R3 frame refreshed", {6'd0, status[3:2]}, 8'd2);
    chk("R3 err_frm", {6'd0, err_op, err_frm}, 8'd3);
    cyc(2);
    chk("R3 hold", {6'd0, status[3:2]}, 8'd2);
    rd_data = 1; cyc(); rd_data = 0;
    chk("R1 ready cleared", {7'd0, status[0]}, 8'd0);
    chk("R2 overrun held", {7'd0, status[1]}, 8'd1);
    rx_load = 1; cyc(); rx_load = 0;
    chk("R2 overrun rewritten", {6'd0, status[1:0]}, 8'd1);
    rx_load = 1; rd_data = 1; cyc(); rx_load = 0; rd_data = 0;
    chk("R1 load wins / R2 read", {6'd0, status[1:0]}, 8'd1);
    rd_data = 1; cyc(); rd_data = 0;
    chk("R1 cleared again", {7'd0, status[0]}, 8'd0);
  endtask

  task automatic t_ext;
    ext_stat_n = 0; cyc(4);
    chk("R4 ext low", {7'd0, status[4]}, 8'd1);
    ext_stat_n = 1; cyc(4);
    chk("R4 ext high", {7'd0, status[4]}, 8'd0);
  endtask

  task automatic t_psi;
    ctl_ie = 1;
    periph_stat = 0; cyc(5);
    chk("R5 psi set", {7'd0, status[5]}, 8'd1);
    chk("R11 psi irq", {7'd0, irq_n}, 8'd0);
    rd_status = 1; cyc(); rd_status = 0; cyc();
    chk("R5 psi cleared", {7'd0, status[5]}, 8'd0);
    chk("R11 psi released", {7'd0, irq_n}, 8'd1);
    periph_stat = 1; cyc(5);
    chk("R5 rise ignored", {7'd0, status[5]}, 8'd0);
  endtask

  task automatic t_tx;
    ctl_ie = 1; ctl_tr = 0;
    wr_char = 1; cyc(); wr_char = 0;
    chk("R6 thre cleared", status[7:6], 8'b01);
    cyc(2);
    chk("R9 no irq", {7'd0, irq_n}, 8'd1);
    tx_hold_xfer = 1; cyc(); tx_hold_xfer = 0;
    chk("R6 xfer", {6'd0, status[7:6]}, 8'b10);
    cyc(2);
    chk("R9 gated by tr", {7'd0, irq_n}, 8'd1);
    ctl_tr = 1; cyc();
    chk("R9 thre irq", {7'd0, irq_n}, 8'd0);
    rd_status = 1; cyc(); rd_status = 0; cyc();
    chk("R9 cleared by status read", {7'd0, irq_n}, 8'd1);
    ctl_tr = 0;
    tx_shift_done = 1; cyc(); tx_shift_done = 0;
    chk("R6 tsre set", {6'd0, status[7:6]}, 8'b11);
    cyc(2);
    chk("R10 idle irq", {7'd0, irq_n}, 8'd0);
    wr_char = 1; cyc(); wr_char = 0; cyc();
    chk("R10 cleared by write", {7'd0, irq_n}, 8'd1);
    tx_hold_xfer = 1; cyc(); tx_hold_xfer = 0;
    tx_shift_done = 1; cyc(); tx_shift_done = 0;
    wr_char = 1; tx_hold_xfer = 1; cyc(); wr_char = 0; tx_hold_xfer = 0;
    chk("R6 write wins", {6'd0, status[7:6]}, 8'b00);
    tx_hold_xfer = 1; cyc(); tx_hold_xfer = 0;
    tx_shift_done = 1; cyc(); tx_shift_done = 0;
    cyc(2);
    rd_status = 1; cyc(); rd_status = 0; cyc();
    chk("R10 cleared by status read", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_cts;
    ctl_ie = 1;
    cts = 1; cyc(5);
    chk("R12 cts irq", {7'd0, irq_n}, 8'd0);
    rd_status = 1; cyc(); rd_status = 0; cyc();
    chk("R12 cleared", {7'd0, irq_n}, 8'd1);
    cts = 0; cyc(4);
    wr_char = 1; cyc(); wr_char = 0;
    cts = 1; cyc(5);
    chk("R12 ignored when busy", {7'd0, irq_n}, 8'd1);
    cts = 0;
    tx_hold_xfer = 1; cyc(); tx_hold_xfer = 0;
    tx_shift_done = 1; cyc(); tx_shift_done = 0;
    cyc(3);
    rd_status = 1; cyc(); rd_status = 0; cyc();
  endtask

  task automatic t_mask;
    ctl_ie = 0;
    rx_load = 1; cyc(); rx_load = 0; cyc();
    chk("R7 masked", {7'd0, irq_n}, 8'd1);
    ctl_ie = 1; cyc();
    chk("R8 data irq", {7'd0, irq_n}, 8'd0);
    rd_data = 1; cyc(); rd_data = 0;
    chk("R8 released by read", {7'd0, irq_n}, 8'd1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_rx();
    t_ext();
    t_psi();
    t_tx();
    t_cts();
    t_mask();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule